// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block supplies the address for a memory array during a four-beat burst. When a burst starts it captures the full external address. After that only the two lowest address bits move. The upper bits stay frozen until the next start.

Each advance steps an internal two-bit beat count. The low address bits are built from the captured start bits and that count, in one of two orders picked by a mode input. In interleaved order the start bits are XORed with the count. In linear order the count is added to the start bits modulo four, so the burst wraps inside its aligned group of four words.

A hold request freezes the current address. The surrounding cycle controller decides when to start, advance or hold; this block only follows those requests. In simulation the mode input acts as if pulled high: any value other than a clean 0 selects interleaved order.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `addr_out` is all zeros.
- R2: A cycle with `start` high loads `ext_addr` and clears the beat count. In the next cycle `addr_out` equals that `ext_addr` in either mode.
- R3: With `mode` = 1 (interleaved), `addr_out[1:0]` = start bits XOR count. Start 01 gives 01,00,11,10 and start 11 gives 11,10,01,00.
- R4: With `mode` = 0 (linear), `addr_out[1:0]` = (start bits + count) mod 4. Start 10 gives 10,11,00,01 and start 11 gives 11,00,01,10.
- R5: `addr_out` bits above bit 1 change only in the cycle after a `start`.
- R6: A cycle with `advance` high, `start` low and `hold` low increments the beat count by one, modulo four. After four advances the low bits are back at the start bits.
- R7: A cycle with `hold` high and `start` low keeps the beat count, even if `advance` is also high. `start` takes priority over both `hold` and `advance`.
- R8: The order is chosen from the present value of `mode`. A change of `mode` alters `addr_out` in the same cycle, without a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load `ext_addr` and begin a new burst |
| advance | input | 1 | Step to the next beat |
| hold | input | 1 | Keep the current beat |
| mode | input | 1 | 1 = interleaved order, 0 = linear order |
| ext_addr | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Address presented to the memory array |

## Verification
Directed bursts are run from all four start values in both modes, with five or more advances each. The two orders are identical for starts 00 and 10 and differ for 01 and 11, so the odd starts are what tell the modes apart. The fifth advance shows whether the count wraps or stops. A pseudo-random phase then mixes start, advance, hold and mode changes in the same cycle. This tests the priority between the three requests, the freezing of the upper bits, and whether a mode change takes effect at once. A behavioural model in the bench is compared with `addr_out` on every clock.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              advance,
  input  logic              hold,
  input  logic              mode,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  beat_q;
  logic [CNT_W-1:0]  low_bits;
  logic              linear;

  // anything but a clean 0 behaves as the pulled-up interleaved setting
  assign linear   = (mode === 1'b0);
  assign low_bits = linear ? base_q[CNT_W-1:0] + beat_q
                           : base_q[CNT_W-1:0] ^ beat_q;
  assign addr_out = {base_q[ADDR_W-1:CNT_W], low_bits};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (start) begin
      base_q <= ext_addr;
      beat_q <= '0;
    end else if (!hold && advance) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> addr_out == $past(ext_addr));

  assert_upper_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(addr_out[ADDR_W-1:CNT_W]));

  assert_advance_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !hold && advance) |=> beat_q == $past(beat_q) + 2'd1);

  assert_hold_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && hold) |=> $stable(beat_q));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> beat_q == '0);

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, advance = 1'b0, hold = 1'b0, mode = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int errors = 0;
  int m_base = 0;
  int m_cnt  = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
    .hold(hold), .mode(mode), .ext_addr(ext_addr), .addr_out(addr_out)
  );

  function automatic int expect_addr(input int base, input int cnt, input logic m);
    int lo;
    if (m) lo = (base % 4) ^ cnt;
    else   lo = ((base % 4) + cnt) % 4;
    return (base / 4) * 4 + lo;
  endfunction

  task automatic compare(input string tag);
    int exp_v;
    exp_v = expect_addr(m_base, m_cnt, mode);
    checks++;
    if (addr_out !== exp_v[AW-1:0]) begin
      errors++;
      $display("FAIL %s: addr_out=%h expected=%h (base=%h cnt=%0d mode=%b)",
               tag, addr_out, exp_v[AW-1:0], m_base[AW-1:0], m_cnt, mode);
    end
  endtask

  // drive one clock with the given controls, update the model, compare at negedge
  task automatic cyc(input logic s, input logic a, input logic h,
                     input logic m, input logic [AW-1:0] ea, input string tag);
    start = s; advance = a; hold = h; mode = m; ext_addr = ea;
    @(posedge clk);
    if (s) begin m_base = int'(ea); m_cnt = 0; end
    else if (!h && a) m_cnt = (m_cnt + 1) % 4;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string tg;
    repeat (3) @(negedge clk);
    checks++;
    if (addr_out !== '0) begin
      errors++;
      $display("FAIL R1: addr_out=%h expected=0000 in reset", addr_out);
    end
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b1, '0, "R1");

    // directed bursts: every start value in both orders, five advances (R6 wrap)
    for (int md = 0; md < 2; md++) begin
      for (int st = 0; st < 4; st++) begin
        tg = md ? "R3" : "R4";
        cyc(1'b1, 1'b0, 1'b0, md[0], AW'(16'hA5F0 + st), "R2");
        for (int b = 0; b < 5; b++) begin
          cyc(1'b0, 1'b1, 1'b0, md[0], AW'(16'h1234), b == 4 ? "R6" : tg);
        end
        cyc(1'b0, 1'b1, 1'b1, md[0], '0, "R7");
        cyc(1'b0, 1'b1, 1'b0, md[0], '0, tg);
        cyc(1'b0, 1'b1, 1'b0, ~md[0], '0, "R8");
      end
    end

    // start wins over hold and advance
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 16'h7FFF, "R7");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, "R5");

    // mixed pseudo-random traffic
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cyc(lfsr[3:0] == 4'd0, lfsr[5], lfsr[8] & lfsr[9], lfsr[12] | lfsr[13],
          lfsr[31:16], "R5");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule